// File: doc/BRIEF.md
# Interrupt Pending and Enable Register Pair

This block keeps the machine-level interrupt-pending and interrupt-enable registers of one hart. Interrupt cause number i sits at bit i of both registers. Software reaches them through a CSR port that can write, set bits, clear bits or only read. A two-bit select on that port picks the machine pending view, the machine enable view, or the supervisor-level pending or enable view. The supervisor views show and accept only the bits whose delegation bit is set.

The machine external, timer and software pending bits follow hardware lines and cannot be changed through the CSR port. When supervisor mode is built in, the three supervisor pending bits can be written by software. The supervisor external pending bit is also ORed with a line from an external interrupt controller. That OR is what a read returns and what the decision logic sees. A set-bits or clear-bits operation, however, starts from the software bit alone. The effective pending and enable vectors go to the interrupt decision logic every cycle.

Top module: `irq_pend_en_regs`

## Requirements
- R1: After reset, every software-writable pending bit and every enable bit is 0, so `pendOut` carries only the hardware lines and `enOut` is 0.
- R2: `pendOut` and a machine-pending read carry `hwMachExt` at bit 11, `hwMachTimer` at bit 7 and `hwMachSoft` at bit 3 in the same cycle. CSR writes never change these three bits.
- R3: Opcode `csrOp` values are: 0 = write, 1 = set bits, 2 = clear bits, 3 = read only. Select `csrSel` values are: 0 = machine pending, 1 = machine enable, 2 = supervisor pending, 3 = supervisor enable. An accepted operation (`csrValid`=1) updates its register at the clock edge, and the new value shows on the next cycle. A read-only or invalid cycle changes nothing. `csrRdata` shows the selected view combinationally.
- R4: With supervisor mode present, pending bits 1, 5 and 9 are software-writable, and enable bits 1, 3, 5, 7, 9 and 11 are writable. Every other bit in 15:0 reads 0 in both registers.
- R5: Pending bit 9 in `pendOut` and in a pending read is the OR of the software bit and `hwSupExtLine`.
- R6: A set-bits or clear-bits operation on pending takes bit 9 from the software bit only, ignoring `hwSupExtLine`. Two examples: setting bit 1 while the line is high leaves software bit 9 at 0, and clearing bit 1 leaves software bit 9 at 1.
- R7: Supervisor views read the machine value ANDed with `delegMask`. Their write, set and clear operations change only bits whose `delegMask` bit is 1.
- R8: Bits 16 and above ignore writes and read 0 in every view and in both outputs.
- R9: With `HAS_SMODE`=0, pending bits 1, 5 and 9 and enable bits 1, 5 and 9 are always 0, including when `hwSupExtLine` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrValid | input | 1 | CSR operation present this cycle |
| csrOp | input | 2 | 0 write, 1 set, 2 clear, 3 read only |
| csrSel | input | 2 | 0 machine pending, 1 machine enable, 2 supervisor pending, 3 supervisor enable |
| csrWdata | input | XLEN | Operand for write, set or clear |
| csrRdata | output | XLEN | Selected view, combinational |
| hwMachExt | input | 1 | Machine external interrupt line |
| hwMachTimer | input | 1 | Machine timer interrupt line |
| hwMachSoft | input | 1 | Machine software interrupt line |
| hwSupExtLine | input | 1 | Supervisor external line from the interrupt controller |
| delegMask | input | XLEN | Delegation mask for the supervisor views |
| pendOut | output | XLEN | Effective pending vector |
| enOut | output | XLEN | Enable vector |

## Verification
Reads and hardware-line effects are combinational, so `csrRdata` and `pendOut` are due in the same cycle as the stimulus. Register updates from write, set and clear are due one clock edge later. The bench drives inputs on the falling edge and compares all outputs 2 ns later against a behavioural model. It advances the model only at the rising edge, so each result is compared in the cycle it falls due. A second instance built without supervisor mode runs against its own model on the same stimulus.

// File: rtl/irqcsr_pkg.sv
package irqcsr_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_READ  = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    SEL_MPEND = 2'd0,
    SEL_MEN   = 2'd1,
    SEL_SPEND = 2'd2,
    SEL_SEN   = 2'd3
  } csr_sel_e;

  localparam int IDX_SSW  = 1;
  localparam int IDX_MSW  = 3;
  localparam int IDX_STM  = 5;
  localparam int IDX_MTM  = 7;
  localparam int IDX_SEX  = 9;
  localparam int IDX_MEX  = 11;
  localparam int STD_BITS = 16;

  typedef struct packed {
    logic    pendWe;
    logic    enWe;
    logic    selPend;
    logic    supView;
    csr_op_e op;
  } ctl_strobe_t;

  function automatic logic [STD_BITS-1:0] stdPendWmask(input bit hasS);
    logic [STD_BITS-1:0] m;
    m = '0;
    if (hasS) begin
      m[IDX_SSW] = 1'b1;
      m[IDX_STM] = 1'b1;
      m[IDX_SEX] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [STD_BITS-1:0] stdEnWmask(input bit hasS);
    logic [STD_BITS-1:0] m;
    m = stdPendWmask(hasS);
    m[IDX_MSW] = 1'b1;
    m[IDX_MTM] = 1'b1;
    m[IDX_MEX] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_csr_ctrl.sv
module irq_csr_ctrl
  import irqcsr_pkg::*;
(
  input  logic        csrValid,
  input  logic [1:0]  csrOp,
  input  logic [1:0]  csrSel,
  output ctl_strobe_t stb
);
  csr_op_e  opKind;
  csr_sel_e selKind;
  logic     modifies;

  always_comb begin
    opKind   = csr_op_e'(csrOp);
    selKind  = csr_sel_e'(csrSel);
    modifies = csrValid && (opKind != OP_READ);
    stb.op      = opKind;
    stb.selPend = (selKind == SEL_MPEND) || (selKind == SEL_SPEND);
    stb.supView = (selKind == SEL_SPEND) || (selKind == SEL_SEN);
    stb.pendWe  = modifies && stb.selPend;
    stb.enWe    = modifies && !stb.selPend;
  end
endmodule

// File: rtl/irq_csr_datapath.sv
module irq_csr_datapath
  import irqcsr_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_strobe_t     stb,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  input  logic            hwMachExt,
  input  logic            hwMachTimer,
  input  logic            hwMachSoft,
  input  logic            hwSupExtLine,
  input  logic [XLEN-1:0] delegMask,
  output logic [XLEN-1:0] pendOut,
  output logic [XLEN-1:0] enOut
);
  localparam int UPPER = XLEN - STD_BITS;
  localparam logic [XLEN-1:0] PEND_WMASK = {{UPPER{1'b0}}, stdPendWmask(HAS_SMODE)};
  localparam logic [XLEN-1:0] EN_WMASK   = {{UPPER{1'b0}}, stdEnWmask(HAS_SMODE)};

  logic [XLEN-1:0] pendSwQ, enQ;
  logic [XLEN-1:0] hwVec, pendView, viewMask, oldVal, newVal;
  logic [XLEN-1:0] pendMask, enMask, pendNext, enNext;
  logic            seiLine;

  generate
    if (HAS_SMODE) begin : g_sline
      assign seiLine = hwSupExtLine;
    end else begin : g_noline
      assign seiLine = 1'b0;
    end
  endgenerate

  always_comb begin
    hwVec          = '0;
    hwVec[IDX_MEX] = hwMachExt;
    hwVec[IDX_MTM] = hwMachTimer;
    hwVec[IDX_MSW] = hwMachSoft;
    hwVec[IDX_SEX] = seiLine;
    pendView       = pendSwQ | hwVec;
    viewMask       = stb.supView ? delegMask : '1;
    // read-modify-write source: software bits only
    oldVal         = stb.selPend ? pendSwQ : enQ;
    unique case (stb.op)
      OP_WRITE: newVal = csrWdata;
      OP_SET:   newVal = oldVal | csrWdata;
      OP_CLEAR: newVal = oldVal & ~csrWdata;
      default:  newVal = oldVal;
    endcase
    pendMask = PEND_WMASK & viewMask;
    enMask   = EN_WMASK & viewMask;
    pendNext = stb.pendWe ? ((pendSwQ & ~pendMask) | (newVal & pendMask)) : pendSwQ;
    enNext   = stb.enWe   ? ((enQ & ~enMask) | (newVal & enMask)) : enQ;
    csrRdata = (stb.selPend ? pendView : enQ) & viewMask;
    pendOut  = pendView;
    enOut    = enQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendSwQ <= '0;
      enQ     <= '0;
    end else begin
      pendSwQ <= pendNext;
      enQ     <= enNext;
    end
  end
endmodule

// File: rtl/irq_pend_en_regs.sv
module irq_pend_en_regs
  import irqcsr_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrValid,
  input  logic [1:0]      csrOp,
  input  logic [1:0]      csrSel,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  input  logic            hwMachExt,
  input  logic            hwMachTimer,
  input  logic            hwMachSoft,
  input  logic            hwSupExtLine,
  input  logic [XLEN-1:0] delegMask,
  output logic [XLEN-1:0] pendOut,
  output logic [XLEN-1:0] enOut
);
  ctl_strobe_t stb;

  irq_csr_ctrl u_ctrl (
    .csrValid(csrValid),
    .csrOp   (csrOp),
    .csrSel  (csrSel),
    .stb     (stb)
  );

  irq_csr_datapath #(.XLEN(XLEN), .HAS_SMODE(HAS_SMODE)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .csrWdata    (csrWdata),
    .csrRdata    (csrRdata),
    .hwMachExt   (hwMachExt),
    .hwMachTimer (hwMachTimer),
    .hwMachSoft  (hwMachSoft),
    .hwSupExtLine(hwSupExtLine),
    .delegMask   (delegMask),
    .pendOut     (pendOut),
    .enOut       (enOut)
  );
endmodule

// File: rtl/irq_csr_checker.sv
module irq_csr_checker
  import irqcsr_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter bit HAS_SMODE = 1'b1
) (
  input logic            clk,
  input logic            rstN,
  input logic            csrValid,
  input logic [1:0]      csrOp,
  input logic [1:0]      csrSel,
  input logic [XLEN-1:0] csrWdata,
  input logic [XLEN-1:0] csrRdata,
  input logic            hwMachExt,
  input logic            hwMachTimer,
  input logic            hwMachSoft,
  input logic            hwSupExtLine,
  input logic [XLEN-1:0] delegMask,
  input logic [XLEN-1:0] pendOut,
  input logic [XLEN-1:0] enOut
);
  localparam logic [XLEN-1:0] EN_OK = {{(XLEN-STD_BITS){1'b0}}, stdEnWmask(HAS_SMODE)};

  AST_MACH_LINES: assert property (@(posedge clk) disable iff (!rstN)
    pendOut[IDX_MEX] == hwMachExt && pendOut[IDX_MTM] == hwMachTimer && pendOut[IDX_MSW] == hwMachSoft); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!csrValid || csrOp == 2'd3) |=> $stable(enOut)); // R3
  AST_EN_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (enOut & ~EN_OK) == '0); // R4
  AST_SEI_OR: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_SMODE && hwSupExtLine) |-> pendOut[IDX_SEX]); // R5
  AST_SUP_MASK: assert property (@(posedge clk) disable iff (!rstN)
    csrSel[1] |-> ((csrRdata & ~delegMask) == '0)); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    pendOut[XLEN-1:STD_BITS] == '0 && enOut[XLEN-1:STD_BITS] == '0 && csrRdata[XLEN-1:STD_BITS] == '0); // R8
  AST_NO_SUP: assert property (@(posedge clk) disable iff (!rstN)
    !HAS_SMODE |-> (pendOut[IDX_SSW] == 1'b0 && pendOut[IDX_STM] == 1'b0 && pendOut[IDX_SEX] == 1'b0)); // R9
endmodule

bind irq_pend_en_regs irq_csr_checker #(.XLEN(XLEN), .HAS_SMODE(HAS_SMODE)) u_chk (.*);

// File: tb/sim_irq_pend_en_regs.sv
`timescale 1ns/1ps
module sim_irq_pend_en_regs;
  localparam int XL = 64;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrValid = 1'b0;
  logic [1:0] csrOp = 2'd3, csrSel = 2'd0;
  logic [XL-1:0] csrWdata = '0, delegMask = '0;
  logic hwME = 1'b0, hwMT = 1'b0, hwMS = 1'b0, hwSL = 1'b0;
  logic [XL-1:0] rd0, po0, eo0, rd1, po1, eo1;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [XL-1:0] swP [2];
  logic [XL-1:0] enM [2];

  always #5 clk = ~clk;

  irq_pend_en_regs #(.XLEN(XL), .HAS_SMODE(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrOp(csrOp), .csrSel(csrSel),
    .csrWdata(csrWdata), .csrRdata(rd0), .hwMachExt(hwME), .hwMachTimer(hwMT),
    .hwMachSoft(hwMS), .hwSupExtLine(hwSL), .delegMask(delegMask), .pendOut(po0), .enOut(eo0));

  irq_pend_en_regs #(.XLEN(XL), .HAS_SMODE(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrOp(csrOp), .csrSel(csrSel),
    .csrWdata(csrWdata), .csrRdata(rd1), .hwMachExt(hwME), .hwMachTimer(hwMT),
    .hwMachSoft(hwMS), .hwSupExtLine(hwSL), .delegMask(delegMask), .pendOut(po1), .enOut(eo1));

  function automatic logic [XL-1:0] wmP(int k);
    return (k == 0) ? 64'h222 : 64'h0;
  endfunction
  function automatic logic [XL-1:0] wmE(int k);
    return (k == 0) ? 64'hAAA : 64'h888;
  endfunction
  function automatic logic [XL-1:0] pendFull(int k);
    logic [XL-1:0] v;
    v = swP[k];
    if (hwME) v = v | (64'h1 << 11);
    if (hwMT) v = v | (64'h1 << 7);
    if (hwMS) v = v | (64'h1 << 3);
    if (hwSL && k == 0) v = v | (64'h1 << 9);
    return v;
  endfunction
  function automatic logic [XL-1:0] viewOf(int k);
    logic [XL-1:0] vm;
    vm = csrSel[1] ? delegMask : '1;
    return ((csrSel[0] == 1'b0) ? pendFull(k) : enM[k]) & vm;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(rd0 == viewOf(0), {tag, " rdata0"}, rd0, viewOf(0));
    chk(po0 == pendFull(0), {tag, " pend0"}, po0, pendFull(0));
    chk(eo0 == enM[0], {tag, " en0"}, eo0, enM[0]);
    chk(rd1 == viewOf(1), {tag, " rdata1 R9"}, rd1, viewOf(1));
    chk(po1 == pendFull(1), {tag, " pend1 R9"}, po1, pendFull(1));
    chk(eo1 == enM[1], {tag, " en1 R9"}, eo1, enM[1]);
  endtask

  task automatic modelUpdate();
    logic [XL-1:0] vm, old, nv, m;
    if (csrValid && csrOp != 2'd3) begin
      for (int k = 0; k < 2; k++) begin
        vm  = csrSel[1] ? delegMask : '1;
        old = (csrSel[0] == 1'b0) ? swP[k] : enM[k];
        nv  = (csrOp == 2'd0) ? csrWdata : (csrOp == 2'd1) ? (old | csrWdata) : (old & ~csrWdata);
        if (csrSel[0] == 1'b0) begin
          m = wmP(k) & vm;
          swP[k] = (swP[k] & ~m) | (nv & m);
        end else begin
          m = wmE(k) & vm;
          enM[k] = (enM[k] & ~m) | (nv & m);
        end
      end
    end
  endtask

  // caller is at a falling edge
  task automatic step(input bit v, input logic [1:0] op, input logic [1:0] sel,
                      input logic [XL-1:0] wd, input string tag);
    csrValid = v; csrOp = op; csrSel = sel; csrWdata = wd;
    #2;
    compareAll(tag);
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    csrValid = 1'b0; csrOp = 2'd3;
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin swP[k] = '0; enM[k] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    #1;
    chk(eo0 == '0 && po0 == '0, "R1 reset", eo0 | po0, '0);
    @(negedge clk);
    step(1'b0, 2'd3, 2'd1, '0, "R1");

    // R2 hardware lines, writes ignored
    hwME = 1; hwMS = 1;
    step(1'b0, 2'd3, 2'd0, '0, "R2");
    step(1'b1, 2'd0, 2'd0, '1, "R2");
    hwME = 0; hwMS = 0; hwMT = 1;
    #2;
    chk(po0[11:0] == 12'h2A2, "R2 R4 pend after write ones", po0, 64'h2A2);
    chk(po1[11:0] == 12'h080, "R9 pend after write ones", po1, 64'h080);
    @(negedge clk);
    step(1'b1, 2'd2, 2'd0, '1, "R2");
    hwMT = 0;

    // R3 / R4 enable write, set, clear, read-only
    step(1'b1, 2'd0, 2'd1, '1, "R4");
    #2;
    chk(eo0 == 64'hAAA, "R4 R8 enable writable mask", eo0, 64'hAAA);
    chk(eo1 == 64'h888, "R9 enable writable mask", eo1, 64'h888);
    @(negedge clk);
    step(1'b1, 2'd0, 2'd1, '0, "R3");
    step(1'b1, 2'd1, 2'd1, 64'h88, "R3");
    step(1'b1, 2'd2, 2'd1, 64'h8, "R3");
    step(1'b1, 2'd3, 2'd1, '1, "R3");
    step(1'b0, 2'd0, 2'd1, '1, "R3");
    #2;
    chk(eo0 == 64'h80, "R3 set/clear/read-only result", eo0, 64'h80);
    @(negedge clk);

    // R5 / R6 supervisor external OR and rmw source
    step(1'b1, 2'd0, 2'd0, '0, "R6");
    hwSL = 1;
    step(1'b0, 2'd3, 2'd0, '0, "R5");
    step(1'b1, 2'd1, 2'd0, 64'h2, "R6");
    hwSL = 0;
    #2;
    chk(rd0[9] == 1'b0, "R6 set kept software bit 9 low", rd0, rd0 & ~64'h200);
    chk(rd0[1] == 1'b1, "R6 set bit 1", rd0, rd0 | 64'h2);
    @(negedge clk);
    step(1'b1, 2'd1, 2'd0, 64'h200, "R6");
    hwSL = 1;
    step(1'b1, 2'd2, 2'd0, 64'h2, "R6");
    hwSL = 0;
    #2;
    chk(rd0[9] == 1'b1 && rd0[1] == 1'b0, "R6 clear kept software bit 9", rd0, 64'h220 & rd0 | 64'h200);
    @(negedge clk);

    // R7 supervisor views
    delegMask = 64'h20;
    step(1'b1, 2'd0, 2'd3, '1, "R7");
    step(1'b1, 2'd0, 2'd2, '1, "R7");
    #2;
    chk(rd0 == 64'h20, "R7 sup pend view", rd0, 64'h20);
    @(negedge clk);
    delegMask = 64'hFFFF_0000_0000_0202;
    step(1'b1, 2'd2, 2'd3, '1, "R7");
    step(1'b0, 2'd3, 2'd2, '0, "R7");
    step(1'b1, 2'd2, 2'd2, 64'h200, "R7");

    // R8 upper bits
    step(1'b1, 2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_0000, "R8");
    step(1'b1, 2'd1, 2'd0, 64'hFFFF_FFFF_FFFF_0000, "R8");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      hwME = 1'($urandom); hwMT = 1'($urandom); hwMS = 1'($urandom); hwSL = 1'($urandom);
      delegMask = {$urandom, $urandom};
      step(1'($urandom), 2'($urandom), 2'($urandom), {$urandom, $urandom}, "R3 R5 R7 mixed");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule